// File: doc/BRIEF.md
# Timer Tick Enable Generator

This block turns the system clock into one tick-enable strobe for each of five PWM timer channels. Two free-running 8-bit prescalers are shared unevenly between the channels. The first feeds channels 0 and 1. The second feeds channels 2, 3 and 4. Each channel then picks its own power-of-two divide of its group's prescaled strobe. It can instead pick an external tick strobe that belongs to its group.

The channel counters use these strobes as count enables. Everything runs in the system clock domain. The two external strobes must already be synchronised to that clock and be one cycle wide. A prescaler value written while the prescaler is counting waits for the current prescaler interval to finish, so no interval is ever cut short.

Top module: `tick_gen_top`

## Requirements
- R1: The prescaler word carries prescaler 0 in bits [7:0] and prescaler 1 in bits [15:8]. A prescaler value p produces one strobe every p+1 cycles. Channels 0 and 1 are timed from prescaler 0, and channels 2 to 4 from prescaler 1.
- R2: The selector word gives channel c a 4-bit code in bits [4c+3:4c]. A code k from 0 to 4 makes the channel tick on every 2^k-th strobe of its prescaler.
- R3: Codes 5, 6 and 7 make the channel output follow an external strobe in the same cycle. Channels 0 and 1 follow external input 0, and channels 2 to 4 follow external input 1.
- R4: Codes 8 to 15 behave like code 4, which divides the prescaled strobe by 16.
- R5: A new prescaler value is taken only at the prescaler's next terminal count. The interval that is already running finishes at its old length, and the new length applies from the interval after it.
- R6: While rst_n is low, every tick output is low, including the outputs that follow an external strobe.
- R7: In the first cycle after reset is released, both prescalers emit a strobe. The dividers count strobes from that one, so a channel with code k first ticks on the 2^k-th strobe of its prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pre_cfg_i | input | 16 | Prescaler values: group 0 in [7:0], group 1 in [15:8] |
| sel_cfg_i | input | 20 | Per-channel source and divide codes, 4 bits per channel |
| ext0_i | input | 1 | External tick strobe for channels 0 and 1 |
| ext1_i | input | 1 | External tick strobe for channels 2 to 4 |
| tick_o | output | 5 | One tick-enable strobe per channel |

## Verification
Each configuration is applied at reset. The bench then counts the strobes on every channel over a fixed window and compares each count with a count it derives from the prescaler value and the code. The configurations pair different prescaler values with every divide code, with codes 8 and above, and with all three external codes. A wrong field position, a wrong prescaler group or a wrong power of two therefore changes at least one count. The external strobes run with different periods, 3 and 7 cycles, so a channel wired to the wrong group's strobe gives a wrong count. A directed test rewrites a prescaler in the middle of an interval and checks the output cycle by cycle, which separates a load at the terminal count from an immediate load.

// File: rtl/tick_gen_pkg.sv
// Package: default sizes and the source-decode helper shared by the tick generator.
// Assumes the external-select codes sit directly above the largest divide code.
package tick_gen_pkg;
    localparam int unsigned NUM_CH    = 5;   // timer channels served
    localparam int unsigned PRE_W     = 8;   // prescaler value width
    localparam int unsigned SEL_W     = 4;   // per-channel selector width
    localparam int unsigned GRP0_CH   = 2;   // channels timed by prescaler 0
    localparam int unsigned MAX_SHIFT = 4;   // largest power-of-two exponent
    localparam int unsigned EXT_FIRST = 5;   // first code selecting the external strobe
    localparam int unsigned EXT_LAST  = 7;   // last code selecting the external strobe

    typedef enum logic {
        SRC_DIVIDED  = 1'b0,
        SRC_EXTERNAL = 1'b1
    } tick_src_e;
endpackage

// File: rtl/tick_prescaler.sv
// Module: free-running prescaler. Emits a one-cycle strobe every limit+1 cycles.
// Assumes limit_i may change at any time; it is sampled only at the terminal count,
// so the interval in progress always completes at its old length.
module tick_prescaler #(
    parameter int unsigned PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] limit_i,
    output logic             tick_o
);
    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] lim_q;

    // Terminal count: the counter has reached the limit that is in force.
    assign tick_o = (cnt_q == lim_q);

    // Count up; at the terminal count wrap to zero and take the new limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lim_q <= '0;
        end else if (tick_o) begin
            cnt_q <= '0;
            lim_q <= limit_i;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/tick_source_sel.sv
// Module: decodes one channel's selector code into a source choice and a divide exponent.
// Assumes EXT_FIRST > MAX_SHIFT; codes above EXT_LAST fall back to the largest divide.
module tick_source_sel
    import tick_gen_pkg::*;
#(
    parameter int unsigned SEL_W     = 4,
    parameter int unsigned MAX_SHIFT = 4,
    parameter int unsigned EXT_FIRST = 5,
    parameter int unsigned EXT_LAST  = 7,
    localparam int unsigned SHW      = $clog2(MAX_SHIFT + 1)
) (
    input  logic [SEL_W-1:0] code_i,
    output tick_src_e        src_o,
    output logic [SHW-1:0]   shift_o
);
    localparam logic [SEL_W-1:0] EXT_LO = SEL_W'(EXT_FIRST);
    localparam logic [SEL_W-1:0] EXT_HI = SEL_W'(EXT_LAST);
    localparam logic [SEL_W-1:0] DIV_HI = SEL_W'(MAX_SHIFT);

    // Classify the code: external range, legal divide, or clamped divide.
    always_comb begin
        src_o   = SRC_DIVIDED;
        shift_o = SHW'(MAX_SHIFT);
        if (code_i >= EXT_LO && code_i <= EXT_HI) begin
            src_o   = SRC_EXTERNAL;
            shift_o = '0;
        end else if (code_i <= DIV_HI) begin
            shift_o = code_i[SHW-1:0];
        end
    end
endmodule

// File: rtl/tick_divider.sv
// Module: power-of-two divider advanced only by its group's prescaler strobes.
// Assumes shift_i <= MAX_SHIFT; the output is a subset of the prescaler strobes.
module tick_divider #(
    parameter int unsigned MAX_SHIFT = 4,
    localparam int unsigned SHW      = $clog2(MAX_SHIFT + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pre_tick_i,
    input  logic [SHW-1:0] shift_i,
    output logic           div_tick_o
);
    logic [MAX_SHIFT-1:0] cnt_q;
    logic [MAX_SHIFT-1:0] mask;

    // Build a mask of the low shift_i bits of the strobe counter.
    always_comb begin
        for (int b = 0; b < MAX_SHIFT; b++) begin
            mask[b] = (SHW'(b) < shift_i);
        end
    end

    // Fire on the strobe that completes each group of 2^shift_i strobes.
    assign div_tick_o = pre_tick_i && ((cnt_q & mask) == mask);

    // Count prescaler strobes, wrapping naturally at 2^MAX_SHIFT.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (pre_tick_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/tick_gen_top.sv
// Module: tick enable generator for a multi-channel PWM timer.
// Two shared prescalers (channels below GRP0_CH use the first one, the rest use the second),
// a per-channel power-of-two divider, and a per-channel choice of an external strobe.
// Assumes ext0_i/ext1_i are synchronous one-cycle strobes. Outputs are held low in reset.
module tick_gen_top
    import tick_gen_pkg::*;
#(
    parameter int unsigned NUM_CH    = tick_gen_pkg::NUM_CH,
    parameter int unsigned PRE_W     = tick_gen_pkg::PRE_W,
    parameter int unsigned SEL_W     = tick_gen_pkg::SEL_W,
    parameter int unsigned GRP0_CH   = tick_gen_pkg::GRP0_CH,
    parameter int unsigned MAX_SHIFT = tick_gen_pkg::MAX_SHIFT,
    parameter int unsigned EXT_FIRST = tick_gen_pkg::EXT_FIRST,
    parameter int unsigned EXT_LAST  = tick_gen_pkg::EXT_LAST
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [2*PRE_W-1:0]      pre_cfg_i,
    input  logic [NUM_CH*SEL_W-1:0] sel_cfg_i,
    input  logic                    ext0_i,
    input  logic                    ext1_i,
    output logic [NUM_CH-1:0]       tick_o
);
    localparam int unsigned NUM_GRP = 2;
    localparam int unsigned SHW     = $clog2(MAX_SHIFT + 1);

    logic [NUM_GRP-1:0] pre_tick;
    logic [NUM_GRP-1:0] ext_tick;

    // Gather the external strobes by group index.
    assign ext_tick = {ext1_i, ext0_i};

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_pre
        tick_prescaler #(
            .PRE_W (PRE_W)
        ) pre_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .limit_i (pre_cfg_i[g*PRE_W +: PRE_W]),
            .tick_o  (pre_tick[g])
        );
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int unsigned GRP = (c < GRP0_CH) ? 0 : 1;
        tick_src_e      src;
        logic [SHW-1:0] shift;
        logic           div_tick;

        tick_source_sel #(
            .SEL_W     (SEL_W),
            .MAX_SHIFT (MAX_SHIFT),
            .EXT_FIRST (EXT_FIRST),
            .EXT_LAST  (EXT_LAST)
        ) sel_i (
            .code_i  (sel_cfg_i[c*SEL_W +: SEL_W]),
            .src_o   (src),
            .shift_o (shift)
        );

        tick_divider #(
            .MAX_SHIFT (MAX_SHIFT)
        ) div_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .pre_tick_i (pre_tick[GRP]),
            .shift_i    (shift),
            .div_tick_o (div_tick)
        );

        // Choose divided or external strobe; force low while in reset.
        assign tick_o[c] = rst_n &&
            ((src == SRC_EXTERNAL) ? ext_tick[GRP] : div_tick);
    end
endmodule

// File: rtl/tick_gen_chk.sv
// Module: assertion checker bound to tick_gen_top. Observes ports and the internal
// prescaler strobes only; drives nothing.
module tick_gen_chk #(
    parameter int unsigned NUM_CH    = 5,
    parameter int unsigned PRE_W     = 8,
    parameter int unsigned SEL_W     = 4,
    parameter int unsigned GRP0_CH   = 2,
    parameter int unsigned EXT_FIRST = 5,
    parameter int unsigned EXT_LAST  = 7
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [2*PRE_W-1:0]      pre_cfg_i,
    input logic [NUM_CH*SEL_W-1:0] sel_cfg_i,
    input logic                    ext0_i,
    input logic                    ext1_i,
    input logic [NUM_CH-1:0]       tick_o,
    input logic [1:0]              pre_tick
);
    // Outputs stay quiet for as long as reset is held.
    always @(negedge clk) begin
        if (!rst_n) begin
            // R6
            reset_quiet_chk: assert (tick_o == '0);
        end
    end

    for (genvar g = 0; g < 2; g++) begin : g_grp
        // R1
        pre_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pre_tick[g] && pre_cfg_i[g*PRE_W +: PRE_W] != '0) |=> !pre_tick[g]);
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int unsigned GRP = (c < GRP0_CH) ? 0 : 1;
        logic is_ext;
        logic ext_src;
        assign is_ext  = (sel_cfg_i[c*SEL_W +: SEL_W] >= SEL_W'(EXT_FIRST)) &&
                         (sel_cfg_i[c*SEL_W +: SEL_W] <= SEL_W'(EXT_LAST));
        assign ext_src = (GRP == 0) ? ext0_i : ext1_i;

        // R3
        ext_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            is_ext |-> (tick_o[c] == ext_src));

        // R2
        div_on_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!is_ext && tick_o[c]) |-> pre_tick[GRP]);
    end
endmodule

bind tick_gen_top tick_gen_chk #(
    .NUM_CH    (NUM_CH),
    .PRE_W     (PRE_W),
    .SEL_W     (SEL_W),
    .GRP0_CH   (GRP0_CH),
    .EXT_FIRST (EXT_FIRST),
    .EXT_LAST  (EXT_LAST)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pre_cfg_i (pre_cfg_i),
    .sel_cfg_i (sel_cfg_i),
    .ext0_i    (ext0_i),
    .ext1_i    (ext1_i),
    .tick_o    (tick_o),
    .pre_tick  (pre_tick)
);

// File: tb/tick_gen_top_tb_top.sv
// Bench: table-driven strobe counting per configuration, then directed reset and
// prescaler-reload tests. Reports through its own counters.
module tick_gen_top_tb_top;
    localparam int NCH = 5;
    localparam int WIN = 600;

    typedef struct packed {
        logic [15:0] pre;
        logic [19:0] sel;
    } vec_t;

    // Selector nibbles are {ch4,ch3,ch2,ch1,ch0}.
    localparam vec_t VECS [5] = '{
        '{16'h0000, 20'h43210},
        '{16'h0402, 20'h20104},
        '{16'h0001, 20'hC7635},
        '{16'h07FF, 20'hF0910},
        '{16'h0305, 20'h42587}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [15:0]      pre_cfg = '0;
    logic [19:0]      sel_cfg = '0;
    logic             ext0 = 1'b0;
    logic             ext1 = 1'b0;
    logic [NCH-1:0]   tick;
    int               n_run = 0;
    int               n_fail = 0;
    int               counts [NCH];

    always #5 clk = ~clk;

    tick_gen_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pre_cfg_i (pre_cfg),
        .sel_cfg_i (sel_cfg),
        .ext0_i    (ext0),
        .ext1_i    (ext1),
        .tick_o    (tick)
    );

    function automatic logic ext_pat(int grp, int i);
        return (grp == 0) ? (i % 3 == 0) : (i % 7 == 2);
    endfunction

    // Expected strobe count over the window, from R1 to R4 and R7.
    function automatic int exp_count(int code, int p, int grp, int w);
        int k, d, n;
        n = 0;
        if (code >= 5 && code <= 7) begin
            for (int i = 0; i < w; i++) if (ext_pat(grp, i)) n++;
        end else begin
            k = (code > 4) ? 4 : code;
            d = 1 << k;
            for (int i = 0; i < w; i++)
                if (i % (p + 1) == 0 && ((i / (p + 1)) + 1) % d == 0) n++;
        end
        return n;
    endfunction

    task automatic check(string tag, int got, int exp, string what);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    // Hold reset with a configuration applied, release on a falling edge.
    task automatic do_reset(logic [15:0] pre, logic [19:0] sel);
        rst_n = 1'b0; pre_cfg = pre; sel_cfg = sel; ext0 = 1'b0; ext1 = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        // R6: reset holds all outputs low even with external strobes high.
        rst_n = 1'b0; pre_cfg = '0; sel_cfg = 20'h55560; ext0 = 1'b1; ext1 = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk); #1;
        check("R6", int'(tick), 0, "outputs in reset");

        // Table walk: count strobes per channel for each configuration (R1-R4, R7).
        for (int v = 0; v < 5; v++) begin
            do_reset(VECS[v].pre, VECS[v].sel);
            for (int c = 0; c < NCH; c++) counts[c] = 0;
            for (int i = 0; i < WIN; i++) begin
                ext0 = ext_pat(0, i);
                ext1 = ext_pat(1, i);
                #1;
                for (int c = 0; c < NCH; c++) if (tick[c]) counts[c]++;
                @(negedge clk);
            end
            for (int c = 0; c < NCH; c++) begin
                int code, grp, p;
                string tag;
                code = int'(VECS[v].sel[c*4 +: 4]);
                grp  = (c < 2) ? 0 : 1;
                p    = int'(VECS[v].pre[grp*8 +: 8]);
                tag  = (code >= 5 && code <= 7) ? "R3" : (code > 7) ? "R4 R1" : "R2 R1 R7";
                check(tag, counts[c], exp_count(code, p, grp, WIN),
                      $sformatf("vec %0d ch %0d code %0d", v, c, code));
            end
        end

        // R5: prescaler 0 = 3, rewritten to 0 mid-interval at cycle 5.
        do_reset(16'h0003, 20'h00000);
        for (int i = 0; i <= 10; i++) begin
            logic exp_t;
            if (i == 5) pre_cfg[7:0] = 8'h00;
            #1;
            exp_t = (i == 0 || i == 4 || i >= 8);
            check("R5", int'(tick[0]), int'(exp_t), $sformatf("ch0 cycle %0d", i));
            @(negedge clk);
        end

        // R7: first cycle after release, code 1 waits for the second strobe.
        do_reset(16'h0000, 20'h11110);
        #1;
        check("R7", int'(tick), 5'b00001, "first cycle after reset");
        @(negedge clk); #1;
        check("R7", int'(tick), 5'b11111, "second cycle after reset");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule